// File: doc/BRIEF.md
# Dual-Enable Static Memory Array

This block is a 32,768-word by 8-bit static memory with a control interface modelled on asynchronous SRAM, rebuilt in synchronous form. A 15-bit address picks one byte. The bidirectional data pin is split into three signals: a byte input, a byte output and a drive-enable that an outside pad ring would use to control its tristate buffer.

Four plain control pins set the operating mode:
- `cs_n`, an active-low chip select.
- `ce`, an active-high chip enable.
- `we_n`, an active-low write enable.
- `oe_n`, an active-low output enable.

Both chip qualifiers must be active for anything to happen. The block then writes, drives read data, or stays quiet. A write commits on the rising clock edge. Read data appears combinationally from the addressed word.

Inside, the array is organised as 2,048 rows of 16 bytes. Row and column indices are formed from scattered address bits. A 2-bit mode output reports the decoded state. Every pin is a plain level signal, so there is no valid/ready handshake and no back-pressure. The contents are not cleared by reset.

Top module: `dual_enable_sram`

## Requirements
- R1: With `cs_n`=0, `ce`=1, `we_n`=1 and `oe_n`=0, `dout_en` is 1, `dout` equals the byte last written at `addr`, and `mode` reads 0 (read).
- R2: With `cs_n`=0, `ce`=1 and `we_n`=0, `din` is stored at `addr` on the rising clock edge whatever `oe_n` is, and `mode` reads 1 (write).
- R3: While `we_n` is 0, `dout_en` is 0 even when `oe_n` is 0.
- R4: While `cs_n` is 1, no write takes place and `dout_en` is 0. If `ce` is 1, `mode` reads 2 (deselected).
- R5: While `ce` is 0, no write takes place, `dout_en` is 0 and `mode` reads 3 (disabled). This holds even when `cs_n` is also 1.
- R6: While `oe_n` is 1, `dout_en` is 0 for every combination of the other three controls.
- R7: Whenever `dout_en` is 0, `dout` is 0.
- R8: Each of the 15 address bits selects distinct storage. Two addresses that differ in any single bit hold independent bytes.
- R9: A write changes only the addressed byte. Other bytes in the same internal row keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; qualifies checks only, storage is not cleared |
| addr | input | 15 | Byte address |
| cs_n | input | 1 | Chip select, active low |
| ce | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driving |
| dout_en | output | 1 | Tristate drive enable for the data pin |
| mode | output | 2 | Decoded mode: 0 read, 1 write, 2 deselected, 3 disabled |

## Verification
The hardest case to reach from the ports is a write attempt that is blocked. It shows nothing at the outputs during the cycle, so the bench first stores a known byte. It then presents different data with a blocking control (select high, enable low, or both) across a clock edge, and reads the location back afterwards to prove it is unchanged. Address aliasing is found by writing every one-hot address plus zero with distinct bytes before reading any of them back. Row-internal lane isolation is found by writing two columns of the same row.

// File: rtl/dsram_pkg.sv
package dsram_pkg;

  localparam int DATA_W    = 8;
  localparam int ROW_LO_W  = 9;   // addr[8:0]   -> low row bits
  localparam int COL_LO_W  = 3;   // addr[11:9]  -> low column bits
  localparam int ROW_HI_W  = 2;   // addr[13:12] -> high row bits
  localparam int COL_HI_W  = 1;   // addr[14]    -> high column bit
  localparam int ROW_W     = ROW_LO_W + ROW_HI_W;
  localparam int COL_W     = COL_LO_W + COL_HI_W;
  localparam int ADDR_W    = ROW_W + COL_W;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_DESEL = 2'd2,
    MODE_OFF   = 2'd3
  } dsram_mode_e;

endpackage

// File: rtl/dsram_ctrl_decode.sv
module dsram_ctrl_decode
  import dsram_pkg::*;
(
  input  logic        cs_n,
  input  logic        ce,
  input  logic        we_n,
  input  logic        oe_n,
  output dsram_mode_e mode,
  output logic        wr_en,
  output logic        rd_drive
);

  // Disabled outranks deselected; write outranks read.
  always_comb begin
    if (!ce)        mode = MODE_OFF;
    else if (cs_n)  mode = MODE_DESEL;
    else if (!we_n) mode = MODE_WRITE;
    else            mode = MODE_READ;
  end

  assign wr_en    = (mode == MODE_WRITE);
  assign rd_drive = (mode == MODE_READ) && !oe_n;

endmodule

// File: rtl/dsram_addr_map.sv
module dsram_addr_map
  import dsram_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);

  localparam int COL_LO_BASE = ROW_LO_W;
  localparam int ROW_HI_BASE = ROW_LO_W + COL_LO_W;
  localparam int COL_HI_BASE = ROW_HI_BASE + ROW_HI_W;

  assign row = {addr[ROW_HI_BASE +: ROW_HI_W], addr[0 +: ROW_LO_W]};
  assign col = {addr[COL_HI_BASE +: COL_HI_W], addr[COL_LO_BASE +: COL_LO_W]};

endmodule

// File: rtl/dsram_row_array.sv
module dsram_row_array #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_byte
);

  localparam int ROWS   = 1 << ROW_W;
  localparam int COLS   = 1 << COL_W;
  localparam int LINE_W = COLS * DATA_W;

  logic [LINE_W-1:0] lines [ROWS];
  logic [LINE_W-1:0] rd_line;

  always_ff @(posedge clk) begin
    if (wr_en) lines[row][col*DATA_W +: DATA_W] <= din;
  end

  assign rd_line = lines[row];
  assign rd_byte = rd_line[col*DATA_W +: DATA_W];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> lines[$past(row)][$past(col)*DATA_W +: DATA_W] == $past(din)); // R2

endmodule

// File: rtl/dual_enable_sram.sv
module dual_enable_sram
  import dsram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              ce,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [1:0]        mode
);

  dsram_mode_e       mode_q;
  logic              wr_en;
  logic              rd_drive;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [DATA_W-1:0] rd_byte;

  dsram_ctrl_decode u_decode (
    .cs_n     (cs_n),
    .ce       (ce),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .mode     (mode_q),
    .wr_en    (wr_en),
    .rd_drive (rd_drive)
  );

  dsram_addr_map u_map (
    .addr (addr),
    .row  (row),
    .col  (col)
  );

  dsram_row_array #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .row     (row),
    .col     (col),
    .din     (din),
    .rd_byte (rd_byte)
  );

  // Per-bit output gating: bus parks at zero when not driving.
  for (genvar b = 0; b < DATA_W; b++) begin : g_gate
    assign dout[b] = rd_byte[b] & rd_drive;
  end

  assign dout_en = rd_drive;
  assign mode    = mode_q;

  AST_WE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_en); // R3
  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!wr_en && !dout_en)); // R4
  AST_DISABLED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> (mode == 2'd3 && !wr_en)); // R5
  AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en); // R6
  AST_PARKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0)); // R7

endmodule

// File: tb/dual_enable_sram_tb.sv
module dual_enable_sram_tb;

  typedef struct {
    logic       en;
    logic [7:0] data;
    logic [1:0] mode;
    string      tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [14:0] addr = '0;
  logic        cs_n = 1, ce = 1, we_n = 1, oe_n = 1;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;
  logic [1:0]  mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t scb[$];
  logic [7:0] model [int];

  always #5 clk = ~clk;

  dual_enable_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .ce(ce),
    .we_n(we_n), .oe_n(oe_n), .din(din), .dout(dout),
    .dout_en(dout_en), .mode(mode)
  );

  // Driver: apply controls at negedge, push expectation from requirement rules.
  task automatic apply(input logic [14:0] a, input logic c_n, input logic c_e,
                       input logic w_n, input logic o_n, input logic [7:0] d,
                       input string tag);
    exp_t e;
    @(negedge clk);
    addr = a; cs_n = c_n; ce = c_e; we_n = w_n; oe_n = o_n; din = d;
    #1;
    if (!c_e)      e.mode = 2'd3;
    else if (c_n)  e.mode = 2'd2;
    else if (!w_n) e.mode = 2'd1;
    else           e.mode = 2'd0;
    e.en   = (e.mode == 2'd0) && !o_n;
    e.data = e.en ? model[int'(a)] : 8'h00;
    e.tag  = tag;
    scb.push_back(e);
    if (e.mode == 2'd1) model[int'(a)] = d;  // commits at next posedge
  endtask

  // Monitor: compare outputs against queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (scb.size() > 0) begin
        exp_t e;
        e = scb.pop_front();
        checks++;
        if (dout_en !== e.en || dout !== e.data || mode !== e.mode) begin
          fails++;
          $display("FAIL %s: got en=%0b dout=%02h mode=%0d, expected en=%0b dout=%02h mode=%0d",
                   e.tag, dout_en, dout, mode, e.en, e.data, e.mode);
        end
      end
    end
  end

  initial begin
    #500us;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state: idle controls, deselected (R4)
    apply(15'h0, 1, 1, 1, 0, 8'h00, "R4 reset deselected");
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R8: write zero and every one-hot address, then read all back
    apply(15'h0, 0, 1, 0, 1, 8'hA5, "R2 write addr0");
    for (int b = 0; b < 15; b++)
      apply(15'(1 << b), 0, 1, 0, 1, 8'(b * 17 + 3), "R2 write onehot");
    apply(15'h0, 0, 1, 1, 0, 8'h00, "R1 R8 read addr0");
    for (int b = 0; b < 15; b++)
      apply(15'(1 << b), 0, 1, 1, 0, 8'h00, "R8 read onehot");

    // R2/R3: write with output enable asserted; no drive during write
    apply(15'h1234, 0, 1, 0, 0, 8'h3C, "R3 write with oe low");
    apply(15'h1234, 0, 1, 1, 0, 8'h00, "R2 readback oe-low write");

    // R4: deselected write attempt leaves storage unchanged
    apply(15'h1234, 1, 1, 0, 0, 8'hFF, "R4 blocked write desel");
    apply(15'h1234, 0, 1, 1, 0, 8'h00, "R4 readback after desel");

    // R5: disabled write attempt, and disabled+deselected priority
    apply(15'h1234, 0, 0, 0, 0, 8'hEE, "R5 blocked write disabled");
    apply(15'h1234, 1, 0, 0, 0, 8'hDD, "R5 disabled over desel");
    apply(15'h1234, 0, 1, 1, 0, 8'h00, "R5 readback after disabled");

    // R6/R7: output enable high under every other control combination
    for (int k = 0; k < 8; k++)
      apply(15'h1234, k[0], k[1], k[2], 1, 8'h77, "R6 R7 oe high combo");
    apply(15'h1234, 0, 1, 1, 0, 8'h00, "R6 readback after combos");

    // R9: two columns of one row (addr bit 9 and bit 14 are column bits)
    apply(15'h0055, 0, 1, 0, 1, 8'h11, "R9 write col0");
    apply(15'h0255, 0, 1, 0, 1, 8'h22, "R9 write col1");
    apply(15'h4055, 0, 1, 0, 1, 8'h33, "R9 write col8");
    apply(15'h0055, 0, 1, 1, 0, 8'h00, "R9 read col0");
    apply(15'h0255, 0, 1, 1, 0, 8'h00, "R9 read col1");
    apply(15'h4055, 0, 1, 1, 0, 8'h00, "R9 read col8");

    // R1: read with we high but oe high gives no drive, then drive
    apply(15'h4055, 0, 1, 1, 1, 8'h00, "R1 R7 read oe high");
    apply(15'h0001, 0, 1, 1, 0, 8'h00, "R1 read again");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule